// File: doc/BRIEF.md
# Multimodulus Prescaler Cycle Controller

This block steers an external prescaler that offers two, three or four division ratios (R1..R4), so that one full division cycle of the loop divider spans N1·R1 + N2·R2 + N3·R3 + N4·R4 input periods. It is clocked by the prescaler output: every clock edge ends one prescaler period. For each period it presents a registered 2-bit ratio select. Once per full division cycle it raises a one-clock terminal pulse, which is the divided output that goes to the phase comparator.

A single 12-bit counter does all the sequencing. It is loaded with N1 and counts down while R1 is selected. From zero it counts up through cumulative targets, selecting R2, then R3, then R4. In two-ratio mode the R2 count is an 8-bit value. In three- and four-ratio modes the counter wraps at 16 and the targets are cumulative 4-bit sums. A fractional request turns one R1 period of a cycle into an R2 period, which adds one to the total ratio. The mode, the targets and the fractional request are all double-buffered and are taken in only at a cycle boundary.

Top module: `nm_cycle_ctrl`

## Requirements
- R1: While rst_ni is low, mod_sel_o is 00 and div_pulse_o is 0. The first clock edge after release loads the counter from n1_i and takes in the settings without a pulse. That start-up period selects R1, so the first pulse appears in period 1 + (total periods of one cycle) after release.
- R2: Every division cycle begins with exactly N1 periods with mod_sel_o = 00 (R1), for N1 from 1 to 4095 as given on n1_i at the cycle boundary.
- R3: With mode_i = 00 (two ratios), the R1 run is followed by N2 periods with mod_sel_o = 01 (R2). Here N2 is the full 8-bit n2_i and a value of 0 gives 256. The next cycle then starts.
- R4: With mode_i = 01 (three ratios), R2 lasts N2 periods, where N2 = n2_i[3:0]. It is followed by mod_sel_o = 10 (R3) for (t3_i − n2_i[3:0]) mod 16 periods. Here t3_i is the cumulative target N2+N3 mod 16. The next cycle then starts.
- R5: With mode_i = 10 or 11 (four ratios), R3 is additionally followed by mod_sel_o = 11 (R4) for (t4_i − t3_i) mod 16 periods. Here t4_i is the cumulative target N2+N3+N4 mod 16.
- R6: In three- and four-ratio modes, a zero R2 count or an unchanged cumulative target gives a full 16 periods for that ratio.
- R7: When frac_i is 1 at a cycle boundary, the following cycle has N1−1 R1 periods and one extra R2 period. When N1 = 1 the request is disregarded.
- R8: div_pulse_o is high for exactly one period, the first R1 period of each cycle after the start-up cycle, and at no other time.
- R9: Changes to mode_i, n1_i, n2_i, t3_i, t4_i and frac_i during a cycle do not alter that cycle. They take effect from the next cycle boundary.
- R10: mod_sel_o only moves R1→R2→R3→R4 in single steps or returns to R1. A return to R1 coincides with the terminal pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Prescaler output clock, one edge per prescaler period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00 two ratios, 01 three ratios, 10/11 four ratios |
| n1_i | input | 12 | Number of R1 periods per cycle (1..4095) |
| n2_i | input | 8 | R2 count; all 8 bits in two-ratio mode, low 4 bits otherwise |
| t3_i | input | 4 | Cumulative target N2+N3 mod 16 |
| t4_i | input | 4 | Cumulative target N2+N3+N4 mod 16 |
| frac_i | input | 1 | Request one R1→R2 substitution in the next cycle |
| mod_sel_o | output | 2 | Registered ratio select: 00 R1, 01 R2, 10 R3, 11 R4 |
| div_pulse_o | output | 1 | One-period terminal pulse per division cycle |

## Verification
The assertions assume that n1_i is never zero at the edge where the counter reloads. A zero there would make the down-count wrap instead of handing over to R2, and one assertion flags any such load. The bench only drives N1 values of 1 or more. It changes inputs only on falling edges, and either leaves them alone for a whole cycle or changes them on purpose in mid-cycle to probe the double buffering. Expected period counts for each ratio are derived from the per-ratio counts N2, N3 and N4. The bench forms the cumulative targets itself, including the wrap past 15.

// File: rtl/nm_pkg.sv
package nm_pkg;

  typedef enum logic [1:0] {
    SEL_R1 = 2'd0,
    SEL_R2 = 2'd1,
    SEL_R3 = 2'd2,
    SEL_R4 = 2'd3
  } sel_e;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_LOAD,
    OP_DOWN,
    OP_UP,
    OP_CLEAR
  } cnt_op_e;

  localparam logic [1:0] MODE_TWO   = 2'd0;
  localparam logic [1:0] MODE_THREE = 2'd1;

  // final ratio of a division cycle for a given mode
  function automatic sel_e last_sel(input logic [1:0] mode);
    case (mode)
      MODE_TWO:   return SEL_R2;
      MODE_THREE: return SEL_R3;
      default:    return SEL_R4;
    endcase
  endfunction

endpackage

// File: rtl/nm_cfg_shadow.sv
module nm_cfg_shadow #(
  parameter int N2_W  = 8,
  parameter int SUB_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [1:0]       mode_i,
  input  logic [N2_W-1:0]  n2_i,
  input  logic [SUB_W-1:0] t3_i,
  input  logic [SUB_W-1:0] t4_i,
  input  logic             frac_i,
  output logic [1:0]       mode_o,
  output logic [N2_W-1:0]  n2_o,
  output logic [SUB_W-1:0] t3_o,
  output logic [SUB_W-1:0] t4_o,
  output logic             frac_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0;
      n2_o   <= '0;
      t3_o   <= '0;
      t4_o   <= '0;
      frac_o <= 1'b0;
    end else if (capture_i) begin
      mode_o <= mode_i;
      n2_o   <= n2_i;
      t3_o   <= t3_i;
      t4_o   <= t4_i;
      frac_o <= frac_i;
    end
  end

  assert_shadow_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable({mode_o, n2_o, t3_o, t4_o, frac_o}));

endmodule

// File: rtl/nm_updown_counter.sv
module nm_updown_counter
  import nm_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int WIDE_W   = 8,
  parameter int NARROW_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_op_e          op_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             narrow_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] up_next_o
);

  localparam logic [CNT_W-1:0] MASK_WIDE   = CNT_W'((1 << WIDE_W) - 1);
  localparam logic [CNT_W-1:0] MASK_NARROW = CNT_W'((1 << NARROW_W) - 1);
  localparam logic [CNT_W-1:0] NARROW_TOP  = CNT_W'(1 << NARROW_W);

  logic [CNT_W-1:0] cnt_q;

  // up-count wraps at the target width of the active mode
  assign up_next_o = (cnt_q + 1'b1) & (narrow_i ? MASK_NARROW : MASK_WIDE);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case (op_i)
        OP_LOAD:  cnt_q <= load_val_i;
        OP_DOWN:  cnt_q <= cnt_q - 1'b1;
        OP_UP:    cnt_q <= up_next_o;
        OP_CLEAR: cnt_q <= '0;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  // down-count must hand over to R2 before it reaches zero
  assert_down_above_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_DOWN) |-> (cnt_q > CNT_W'(1)));

  // in 16-step modes the up-count stays inside the 4-bit target range
  assert_narrow_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_UP && narrow_i) |-> (cnt_q < NARROW_TOP));

endmodule

// File: rtl/nm_phase_ctrl.sv
module nm_phase_ctrl
  import nm_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int WIDE_W   = 8,
  parameter int NARROW_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic [CNT_W-1:0]    up_next_i,
  input  logic [1:0]          mode_i,
  input  logic [WIDE_W-1:0]   n2_i,
  input  logic [NARROW_W-1:0] t3_i,
  input  logic [NARROW_W-1:0] t4_i,
  input  logic                frac_i,
  output cnt_op_e             op_o,
  output logic                capture_o,
  output logic                narrow_o,
  output sel_e                sel_o,
  output logic                pulse_o
);

  localparam int NUM_UP = 3;

  sel_e sel_q, sel_d;
  logic first_q, first_d;
  logic hold_q, hold_d;
  logic pulse_q, pulse_d;

  logic [CNT_W-1:0]  tgt [NUM_UP];
  logic [NUM_UP-1:0] hit;
  logic              hit_cur;

  assign narrow_o = (mode_i != MODE_TWO);

  assign tgt[0] = narrow_o ? CNT_W'(n2_i[NARROW_W-1:0]) : CNT_W'(n2_i);
  assign tgt[1] = CNT_W'(t3_i);
  assign tgt[2] = CNT_W'(t4_i);

  for (genvar k = 0; k < NUM_UP; k++) begin : g_hit
    assign hit[k] = (up_next_i == tgt[k]);
  end

  always_comb begin
    unique case (sel_q)
      SEL_R2:  hit_cur = hit[0];
      SEL_R3:  hit_cur = hit[1];
      SEL_R4:  hit_cur = hit[2];
      default: hit_cur = 1'b0;
    endcase
  end

  always_comb begin
    sel_d     = sel_q;
    op_o      = OP_HOLD;
    capture_o = 1'b0;
    pulse_d   = 1'b0;
    hold_d    = 1'b0;
    first_d   = 1'b0;
    if (first_q) begin
      capture_o = 1'b1;
      op_o      = OP_LOAD;
      sel_d     = SEL_R1;
    end else if (sel_q == SEL_R1) begin
      if (frac_i && cnt_i == CNT_W'(2)) begin
        // leave R1 one period early; R2 absorbs it via a held count
        sel_d  = SEL_R2;
        op_o   = OP_CLEAR;
        hold_d = 1'b1;
      end else if (cnt_i == CNT_W'(1)) begin
        sel_d = SEL_R2;
        op_o  = OP_CLEAR;
      end else begin
        op_o = OP_DOWN;
      end
    end else if (hold_q) begin
      op_o = OP_HOLD;
    end else if (hit_cur) begin
      if (sel_q == last_sel(mode_i)) begin
        capture_o = 1'b1;
        op_o      = OP_LOAD;
        sel_d     = SEL_R1;
        pulse_d   = 1'b1;
      end else begin
        sel_d = sel_e'(sel_q + 2'd1);
        op_o  = OP_UP;
      end
    end else begin
      op_o = OP_UP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= SEL_R1;
      first_q <= 1'b1;
      hold_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      sel_q   <= sel_d;
      first_q <= first_d;
      hold_q  <= hold_d;
      pulse_q <= pulse_d;
    end
  end

  assign sel_o   = sel_q;
  assign pulse_o = pulse_q;

  // counter never sits at zero while R1 is selected
  assert_r1_count_live_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == SEL_R1 && !first_q) |-> (cnt_i != '0));

  // a held period only follows the fractional early exit from R1
  assert_hold_after_frac_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q |-> (sel_q == SEL_R2 && frac_i));

endmodule

// File: rtl/nm_cycle_ctrl.sv
module nm_cycle_ctrl
  import nm_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int WIDE_W   = 8,
  parameter int NARROW_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          mode_i,
  input  logic [CNT_W-1:0]    n1_i,
  input  logic [WIDE_W-1:0]   n2_i,
  input  logic [NARROW_W-1:0] t3_i,
  input  logic [NARROW_W-1:0] t4_i,
  input  logic                frac_i,
  output logic [1:0]          mod_sel_o,
  output logic                div_pulse_o
);

  logic [1:0]          mode_q;
  logic [WIDE_W-1:0]   n2_q;
  logic [NARROW_W-1:0] t3_q, t4_q;
  logic                frac_q;
  logic                capture;
  logic                narrow;
  cnt_op_e             op;
  sel_e                sel;
  logic [CNT_W-1:0]    cnt, up_next;

  nm_cfg_shadow #(
    .N2_W  (WIDE_W),
    .SUB_W (NARROW_W)
  ) i_shadow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .mode_i    (mode_i),
    .n2_i      (n2_i),
    .t3_i      (t3_i),
    .t4_i      (t4_i),
    .frac_i    (frac_i),
    .mode_o    (mode_q),
    .n2_o      (n2_q),
    .t3_o      (t3_q),
    .t4_o      (t4_q),
    .frac_o    (frac_q)
  );

  nm_phase_ctrl #(
    .CNT_W    (CNT_W),
    .WIDE_W   (WIDE_W),
    .NARROW_W (NARROW_W)
  ) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_i     (cnt),
    .up_next_i (up_next),
    .mode_i    (mode_q),
    .n2_i      (n2_q),
    .t3_i      (t3_q),
    .t4_i      (t4_q),
    .frac_i    (frac_q),
    .op_o      (op),
    .capture_o (capture),
    .narrow_o  (narrow),
    .sel_o     (sel),
    .pulse_o   (div_pulse_o)
  );

  // N1 goes straight into the counter at the boundary, so it needs no shadow
  nm_updown_counter #(
    .CNT_W    (CNT_W),
    .WIDE_W   (WIDE_W),
    .NARROW_W (NARROW_W)
  ) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .load_val_i (n1_i),
    .narrow_i   (narrow),
    .cnt_o      (cnt),
    .up_next_o  (up_next)
  );

  assign mod_sel_o = sel;

  assert_n1_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture |-> (n1_i != '0));

  assert_pulse_in_r1_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_pulse_o |-> (mod_sel_o == SEL_R1));

  assert_pulse_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_pulse_o |=> !div_pulse_o);

  assert_sel_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (mod_sel_o == $past(mod_sel_o)) || (mod_sel_o == SEL_R1) ||
             (mod_sel_o == ($past(mod_sel_o) + 2'd1)));

  assert_wrap_with_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mod_sel_o) != SEL_R1 && mod_sel_o == SEL_R1) |-> div_pulse_o);

  assert_sel_within_mode_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_TWO) |-> (mod_sel_o <= SEL_R2));

  assert_sel_within_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_THREE) |-> (mod_sel_o <= SEL_R3));

endmodule

// File: tb/test_nm_cycle_ctrl.sv
module test_nm_cycle_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_PER    = 5000;

  typedef int cnt4_t [4];

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [1:0]  mode_i;
  logic [11:0] n1_i;
  logic [7:0]  n2_i;
  logic [3:0]  t3_i, t4_i;
  logic        frac_i;
  logic [1:0]  mod_sel_o;
  logic        div_pulse_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bit         alt_pending = 1'b0;
  logic [1:0] alt_m;
  int         alt_n1, alt_n2, alt_n3, alt_n4;
  bit         alt_fr;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  nm_cycle_ctrl i_nm_cycle_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .n1_i        (n1_i),
    .n2_i        (n2_i),
    .t3_i        (t3_i),
    .t4_i        (t4_i),
    .frac_i      (frac_i),
    .mod_sel_o   (mod_sel_o),
    .div_pulse_o (div_pulse_o)
  );

  task automatic check_int(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic apply_cfg(input logic [1:0] m, input int n1, input int n2,
                           input int n3, input int n4, input bit fr);
    mode_i = m;
    n1_i   = 12'(n1);
    n2_i   = 8'(n2);
    t3_i   = 4'(n2 + n3);
    t4_i   = 4'(n2 + n3 + n4);
    frac_i = fr;
  endtask

  function automatic int full16(input int v);
    return (v % 16 == 0) ? 16 : v % 16;
  endfunction

  function automatic cnt4_t calc_exp(input logic [1:0] m, input int n1, input int n2,
                                     input int n3, input int n4, input bit fr);
    cnt4_t e;
    int b;
    b = (fr && n1 >= 2) ? 1 : 0;
    e[0] = n1 - b;
    e[2] = 0;
    e[3] = 0;
    if (m == 2'd0) begin
      e[1] = ((n2 % 256 == 0) ? 256 : n2 % 256) + b;
    end else begin
      e[1] = full16(n2) + b;
      e[2] = full16(n3);
      if (m >= 2'd2) e[3] = full16(n4);
    end
    return e;
  endfunction

  task automatic wait_pulse(input string req);
    bit seen = 1'b0;
    for (int i = 0; i < MAX_PER; i++) begin
      @(negedge clk_i);
      if (div_pulse_o) begin
        seen = 1'b1;
        break;
      end
    end
    check_int(req, "pulse reached", int'(seen), 1);
  endtask

  // starts on the negedge where div_pulse_o is high, ends on the next one
  task automatic measure(input string req, input cnt4_t e);
    int got [4];
    logic [1:0] prev = 2'd0;
    logic [1:0] sel;
    bit bad = 1'b0;
    bit ended = 1'b0;
    int n = 0;
    got = '{0, 0, 0, 0};
    check_int("R8", "select at pulse", int'(mod_sel_o), 0);
    for (int i = 0; i < MAX_PER; i++) begin
      sel = mod_sel_o;
      got[int'(sel)]++;
      if (n > 0 && sel != prev && int'(sel) != int'(prev) + 1) bad = 1'b1;
      prev = sel;
      n++;
      if (alt_pending && n == 2) begin
        apply_cfg(alt_m, alt_n1, alt_n2, alt_n3, alt_n4, alt_fr);
        alt_pending = 1'b0;
      end
      @(negedge clk_i);
      if (div_pulse_o) begin
        ended = 1'b1;
        break;
      end
    end
    check_int(req, "cycle ended", int'(ended), 1);
    check_int(req, "periods sel 00", got[0], e[0]);
    check_int(req, "periods sel 01", got[1], e[1]);
    check_int(req, "periods sel 10", got[2], e[2]);
    check_int(req, "periods sel 11", got[3], e[3]);
    check_int("R10", "select order", int'(bad), 0);
  endtask

  task automatic run_case(input string req, input logic [1:0] m, input int n1, input int n2,
                          input int n3, input int n4, input bit fr);
    apply_cfg(m, n1, n2, n3, n4, fr);
    wait_pulse(req);
    measure(req, calc_exp(m, n1, n2, n3, n4, fr));
  endtask

  task automatic test_reset;
    int k = 0;
    rst_ni = 1'b0;
    apply_cfg(2'd0, 5, 3, 0, 0, 1'b0);
    repeat (3) @(negedge clk_i);
    check_int("R1", "sel in reset", int'(mod_sel_o), 0);
    check_int("R1", "pulse in reset", int'(div_pulse_o), 0);
    rst_ni = 1'b1;
    for (int i = 0; i < MAX_PER; i++) begin
      @(negedge clk_i);
      k++;
      if (k == 1) check_int("R1", "no pulse on start-up load", int'(div_pulse_o), 0);
      if (div_pulse_o) break;
    end
    check_int("R1", "periods to first pulse", k, 1 + 5 + 3);
    measure("R3", calc_exp(2'd0, 5, 3, 0, 0, 1'b0));
  endtask

  task automatic test_two_mod;
    run_case("R3", 2'd0, 17, 40, 0, 0, 1'b0);
  endtask

  task automatic test_three_mod;
    run_case("R4", 2'd1, 4, 3, 5, 0, 1'b0);
    run_case("R4", 2'd1, 2, 14, 7, 0, 1'b0);
  endtask

  task automatic test_four_mod;
    run_case("R5", 2'd2, 3, 2, 7, 4, 1'b0);
    run_case("R5", 2'd3, 2, 9, 10, 6, 1'b0);
  endtask

  task automatic test_zero_full;
    run_case("R6", 2'd1, 3, 0, 0, 0, 1'b0);
    run_case("R6", 2'd2, 1, 5, 0, 0, 1'b0);
    run_case("R3", 2'd0, 2, 0, 0, 0, 1'b0);
  endtask

  task automatic test_frac;
    run_case("R7", 2'd0, 6, 2, 0, 0, 1'b1);
    run_case("R7", 2'd2, 3, 1, 2, 3, 1'b1);
    run_case("R7", 2'd1, 1, 4, 2, 0, 1'b1);
  endtask

  task automatic test_double_buffer;
    apply_cfg(2'd1, 4, 2, 3, 0, 1'b0);
    wait_pulse("R9");
    alt_m  = 2'd0;
    alt_n1 = 7;
    alt_n2 = 5;
    alt_n3 = 0;
    alt_n4 = 0;
    alt_fr = 1'b0;
    alt_pending = 1'b1;
    measure("R9", calc_exp(2'd1, 4, 2, 3, 0, 1'b0));
    measure("R9", calc_exp(2'd0, 7, 5, 0, 0, 1'b0));
  endtask

  task automatic test_long_counts;
    run_case("R2", 2'd0, 300, 200, 0, 0, 1'b0);
  endtask

  initial begin
    rst_ni = 1'b0;
    apply_cfg(2'd0, 5, 3, 0, 0, 1'b0);
    test_reset();
    test_two_mod();
    test_three_mod();
    test_four_mod();
    test_zero_full();
    test_frac();
    test_double_buffer();
    test_long_counts();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule